// File: doc/BRIEF.md
# Display List Walker

This block follows the chain of headers that makes up a compositor channel's display list. The list sits in a shared memory of 32-bit words. Software sets a start-pointer register for each channel. A start pulse for a channel then makes the block read that channel's first header word. It steps from header to header by adding the size field of each header to the header's own address, and it stops when it reads a header with the terminator flag set. For each ordinary header it reports the header's word address, its control word and the channel. Each finished list gives a one-cycle completion strobe, and each malformed list gives a one-cycle error strobe.

The block is shared by several channels. All channels use one memory read port, and a rotating arbiter picks which channel reads. At most one read is issued per clock cycle. The memory returns data one cycle after the request. The first 32 words of the memory hold a list written at boot, and no runtime walk may start inside that region. A channel whose mode input is "off" or "end-of-frame" does not start a walk. Fetching pixels and placing lists in memory are handled by other blocks.

Top module: `dlist_walker`

## Requirements
- R1: After reset, `memReq`, `entValid`, `listDone` and `listErr` are low. Every start-pointer register holds 32, so a walk started with no pointer write begins at word 32.
- R2: A pointer write (`cfgWe`) whose address is below 32 is ignored, and the register keeps its previous value. A write at 32 or above replaces the value. No read is ever issued below word 32.
- R3: A header word carries the terminator flag in bit 31 and the entry size in bits 29:24. For every header without the terminator whose size is non-zero, the block emits `entValid` with that header's address, its control word and the channel. The next header is read at address + size.
- R4: A header with the terminator flag set produces one `listDone` pulse carrying the channel and no entry. The channel then issues no more reads until it is started again.
- R5: `chanMode` holds two bits per channel, with channel i at bits 2i+1:2i. The code 00 means off and 10 means end-of-frame; a start pulse for a channel in either mode is ignored. The codes 01 and 11 allow a walk.
- R6: A header without the terminator and with size 0 produces `listErr` and no entry, and the channel's walk stops.
- R7: If address + size of a non-terminator header is 4096 or more, the block emits that header's entry and raises `listErr` in the same cycle, and the walk stops. A next address of exactly 4095 is still walked.
- R8: When several channels wait to read, grants rotate in channel order, starting after the last channel granted. `memReq` is asserted on consecutive cycles while reads are pending, and no channel is granted on two consecutive cycles.
- R9: When a start pulse is sampled at clock edge k, `memReq` with the start address is visible after edge k. The matching entry or strobe appears after edge k+2.
- R10: A start pulse for a channel that is already walking is ignored: its list is not restarted and no entry repeats.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| cfgWe | input | 1 | Start-pointer write enable |
| cfgChan | input | 2 | Channel whose pointer is written |
| cfgAddr | input | 12 | New start word address |
| chanMode | input | 6 | Two-bit mode per channel |
| startPulse | input | 3 | One-cycle start request per channel |
| memReq | output | 1 | List memory read request |
| memAddr | output | 12 | List memory word address |
| memRdata | input | 32 | Read data, valid the cycle after the request |
| entValid | output | 1 | Entry header reported |
| outChan | output | 2 | Channel of the entry, completion or error |
| entAddr | output | 12 | Word address of the reported header |
| entCtrl | output | 32 | Control word of the reported header |
| listDone | output | 1 | Terminator reached |
| listErr | output | 1 | Zero size or walk past the end of memory |

## Verification
The bench aims at the edges of the chain arithmetic. It places a header at word 4090 with size 6, which must give an entry together with an error. A design with an off-by-one here would either walk past the end or drop the entry. A size of 5 at the same place lands exactly on word 4095, and a wrong bound would flag a valid list as an error there. A zero-size header must stop the walk, because a design that missed this would read the same word forever. Pointer writes into the boot region must leave the old pointer in place. Running three channels at once must give reads that rotate strictly in channel order; a fixed-priority arbiter would starve channel 2 and break that order. A second start pulse in the middle of a walk must not rewind the list.

// File: rtl/dlist_walker_pkg.sv
package dlist_walker_pkg;

  // Upper bound on channels carried by the strobe struct.
  localparam int MAX_CH   = 8;
  localparam int CH_IDX_W = $clog2(MAX_CH);

  typedef enum logic [1:0] {
    CH_IDLE = 2'd0,
    CH_PEND = 2'd1,
    CH_WAIT = 2'd2
  } chState_e;

  // Control-to-datapath strobes.
  typedef struct packed {
    logic [MAX_CH-1:0]   accept;
    logic                launch;
    logic [CH_IDX_W-1:0] launchCh;
    logic                ret;
    logic [CH_IDX_W-1:0] retCh;
  } walkStrobes_t;

  // Datapath-to-control decode of the header being returned.
  typedef struct packed {
    logic isEnd;
    logic sizeZero;
    logic overrun;
  } hdrVerdict_t;

  // Mode codes 01 and 11 allow a walk; 00 (off) and 10 (end-of-frame) do not.
  function automatic logic modeRuns(input logic [1:0] m);
    return m[0];
  endfunction

endpackage

// File: rtl/dlist_walker_ctrl.sv
module dlist_walker_ctrl
  import dlist_walker_pkg::*;
#(
  parameter int NUM_CH = 3
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic [NUM_CH-1:0]   startPulse,
  input  logic [2*NUM_CH-1:0] chanMode,
  input  hdrVerdict_t         verdict,
  output walkStrobes_t        strobes
);

  chState_e            st [NUM_CH];
  logic [NUM_CH-1:0]   pendVec;
  logic [NUM_CH-1:0]   acceptVec;
  logic [CH_IDX_W-1:0] rrPtr;
  logic [CH_IDX_W-1:0] grantIdx;
  logic                launchNow;
  logic                retValid;
  logic [CH_IDX_W-1:0] retCh;
  logic                stopWalk;

  assign stopWalk  = verdict.isEnd | verdict.sizeZero | verdict.overrun;
  assign launchNow = |pendVec;

  always_comb begin
    for (int i = 0; i < NUM_CH; i++) begin
      pendVec[i]   = (st[i] == CH_PEND);
      acceptVec[i] = startPulse[i] && (st[i] == CH_IDLE) &&
                     modeRuns(chanMode[2*i +: 2]);
    end
  end

  // Rotating grant: the smallest offset from rrPtr wins (R8).
  always_comb begin
    grantIdx = '0;
    for (int k = NUM_CH - 1; k >= 0; k--) begin
      if (pendVec[(int'(rrPtr) + k) % NUM_CH])
        grantIdx = CH_IDX_W'((int'(rrPtr) + k) % NUM_CH);
    end
  end

  always_comb begin
    strobes                    = '0;
    strobes.accept[NUM_CH-1:0] = acceptVec;
    strobes.launch             = launchNow;
    strobes.launchCh           = grantIdx;
    strobes.ret                = retValid;
    strobes.retCh              = retCh;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      rrPtr    <= '0;
      retValid <= 1'b0;
      retCh    <= '0;
    end else begin
      retValid <= launchNow;
      if (launchNow) begin
        retCh <= grantIdx;
        rrPtr <= (grantIdx == CH_IDX_W'(NUM_CH - 1)) ? '0 : grantIdx + 1'b1;
      end
    end
  end

  // Per-channel walk state.
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      for (int i = 0; i < NUM_CH; i++) st[i] <= CH_IDLE;
    end else begin
      for (int i = 0; i < NUM_CH; i++) begin
        case (st[i])
          CH_IDLE: if (acceptVec[i]) st[i] <= CH_PEND;
          CH_PEND: if (launchNow && grantIdx == CH_IDX_W'(i)) st[i] <= CH_WAIT;
          CH_WAIT: if (retValid && retCh == CH_IDX_W'(i))
                     st[i] <= stopWalk ? CH_IDLE : CH_PEND;
          default: st[i] <= CH_IDLE;
        endcase
      end
    end
  end

endmodule

// File: rtl/dlist_walker_dp.sv
module dlist_walker_dp
  import dlist_walker_pkg::*;
#(
  parameter int NUM_CH     = 3,
  parameter int MEM_WORDS  = 4096,
  parameter int BOOT_WORDS = 32,
  parameter int DATA_W     = 32,
  parameter int END_BIT    = 31,
  parameter int SIZE_LSB   = 24,
  parameter int SIZE_W     = 6,
  localparam int ADDR_W    = $clog2(MEM_WORDS),
  localparam int CHW       = (NUM_CH > 1) ? $clog2(NUM_CH) : 1
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              cfgWe,
  input  logic [CHW-1:0]    cfgChan,
  input  logic [ADDR_W-1:0] cfgAddr,
  input  walkStrobes_t      strobes,
  input  logic [DATA_W-1:0] memRdata,
  output logic              memReq,
  output logic [ADDR_W-1:0] memAddr,
  output hdrVerdict_t       verdict,
  output logic              entValid,
  output logic [CHW-1:0]    outChan,
  output logic [ADDR_W-1:0] entAddr,
  output logic [DATA_W-1:0] entCtrl,
  output logic              listDone,
  output logic              listErr
);

  logic [ADDR_W-1:0] startReg [NUM_CH];
  logic [ADDR_W-1:0] curAddr  [NUM_CH];
  logic [CHW-1:0]    retSel;
  logic [CHW-1:0]    launchSel;
  logic [ADDR_W-1:0] retAddr;
  logic [SIZE_W-1:0] sizeVal;
  logic              endFlag;
  logic [ADDR_W:0]   nextAddr;
  logic              advance;

  assign retSel    = strobes.retCh[CHW-1:0];
  assign launchSel = strobes.launchCh[CHW-1:0];
  assign memReq    = strobes.launch;
  assign memAddr   = curAddr[launchSel];

  // Header decode (R3, R6, R7).
  assign retAddr  = curAddr[retSel];
  assign sizeVal  = memRdata[SIZE_LSB +: SIZE_W];
  assign endFlag  = memRdata[END_BIT];
  assign nextAddr = {1'b0, retAddr} + (ADDR_W + 1)'(sizeVal);

  assign verdict.isEnd    = strobes.ret && endFlag;
  assign verdict.sizeZero = strobes.ret && !endFlag && (sizeVal == '0);
  assign verdict.overrun  = strobes.ret && !endFlag && (sizeVal != '0) &&
                            (nextAddr >= (ADDR_W + 1)'(MEM_WORDS));
  assign advance = strobes.ret && !verdict.isEnd && !verdict.sizeZero &&
                   !verdict.overrun;

  // Pointer registers and walk cursors (R1, R2, R10).
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      for (int i = 0; i < NUM_CH; i++) begin
        startReg[i] <= ADDR_W'(BOOT_WORDS);
        curAddr[i]  <= ADDR_W'(BOOT_WORDS);
      end
    end else begin
      for (int i = 0; i < NUM_CH; i++) begin
        if (cfgWe && cfgChan == CHW'(i) && cfgAddr >= ADDR_W'(BOOT_WORDS))
          startReg[i] <= cfgAddr;
        if (strobes.accept[i])
          curAddr[i] <= startReg[i];
        else if (advance && retSel == CHW'(i))
          curAddr[i] <= nextAddr[ADDR_W-1:0];
      end
    end
  end

  // Registered output stream (R3, R4, R6, R7).
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      entValid <= 1'b0;
      listDone <= 1'b0;
      listErr  <= 1'b0;
      outChan  <= '0;
      entAddr  <= '0;
      entCtrl  <= '0;
    end else begin
      entValid <= strobes.ret && !endFlag && (sizeVal != '0);
      listDone <= verdict.isEnd;
      listErr  <= verdict.sizeZero | verdict.overrun;
      if (strobes.ret) begin
        outChan <= retSel;
        entAddr <= retAddr;
        entCtrl <= memRdata;
      end
    end
  end

endmodule

// File: rtl/dlist_walker.sv
module dlist_walker
  import dlist_walker_pkg::*;
#(
  parameter int NUM_CH     = 3,
  parameter int MEM_WORDS  = 4096,
  parameter int BOOT_WORDS = 32,
  parameter int DATA_W     = 32,
  parameter int END_BIT    = 31,
  parameter int SIZE_LSB   = 24,
  parameter int SIZE_W     = 6,
  localparam int ADDR_W    = $clog2(MEM_WORDS),
  localparam int CHW       = (NUM_CH > 1) ? $clog2(NUM_CH) : 1
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic                cfgWe,
  input  logic [CHW-1:0]      cfgChan,
  input  logic [ADDR_W-1:0]   cfgAddr,
  input  logic [2*NUM_CH-1:0] chanMode,
  input  logic [NUM_CH-1:0]   startPulse,
  output logic                memReq,
  output logic [ADDR_W-1:0]   memAddr,
  input  logic [DATA_W-1:0]   memRdata,
  output logic                entValid,
  output logic [CHW-1:0]      outChan,
  output logic [ADDR_W-1:0]   entAddr,
  output logic [DATA_W-1:0]   entCtrl,
  output logic                listDone,
  output logic                listErr
);

  walkStrobes_t strobes;
  hdrVerdict_t  verdict;

  dlist_walker_ctrl #(.NUM_CH(NUM_CH)) u_ctrl (
    .clk       (clk),
    .rstN      (rstN),
    .startPulse(startPulse),
    .chanMode  (chanMode),
    .verdict   (verdict),
    .strobes   (strobes)
  );

  dlist_walker_dp #(
    .NUM_CH    (NUM_CH),
    .MEM_WORDS (MEM_WORDS),
    .BOOT_WORDS(BOOT_WORDS),
    .DATA_W    (DATA_W),
    .END_BIT   (END_BIT),
    .SIZE_LSB  (SIZE_LSB),
    .SIZE_W    (SIZE_W)
  ) u_dp (
    .clk     (clk),
    .rstN    (rstN),
    .cfgWe   (cfgWe),
    .cfgChan (cfgChan),
    .cfgAddr (cfgAddr),
    .strobes (strobes),
    .memRdata(memRdata),
    .memReq  (memReq),
    .memAddr (memAddr),
    .verdict (verdict),
    .entValid(entValid),
    .outChan (outChan),
    .entAddr (entAddr),
    .entCtrl (entCtrl),
    .listDone(listDone),
    .listErr (listErr)
  );

endmodule

// File: rtl/dlist_walker_chk.sv
module dlist_walker_chk
  import dlist_walker_pkg::*;
#(
  parameter int MEM_WORDS  = 4096,
  parameter int BOOT_WORDS = 32,
  localparam int ADDR_W    = $clog2(MEM_WORDS)
) (
  input logic              clk,
  input logic              rstN,
  input logic              memReq,
  input logic [ADDR_W-1:0] memAddr,
  input logic              entValid,
  input logic              listDone,
  input logic              listErr,
  input walkStrobes_t      strobes
);

  // R1: outputs stay quiet while reset is held.
  always @(negedge clk) begin
    if (!rstN) begin
      p_reset_quiet_r1: assert (!memReq && !entValid && !listDone && !listErr)
        else $error("outputs active during reset");
    end
  end

  p_no_boot_read_r2: assert property (@(posedge clk) disable iff (!rstN)
    memReq |-> memAddr >= ADDR_W'(BOOT_WORDS));

  p_done_alone_r4: assert property (@(posedge clk) disable iff (!rstN)
    listDone |-> (!entValid && !listErr));

  p_no_repeat_grant_r8: assert property (@(posedge clk) disable iff (!rstN)
    (strobes.launch && $past(strobes.launch)) |->
      (strobes.launchCh != $past(strobes.launchCh)));

  p_ret_after_read_r9: assert property (@(posedge clk) disable iff (!rstN)
    strobes.ret |-> $past(strobes.launch));

  p_out_after_read_r9: assert property (@(posedge clk) disable iff (!rstN)
    (entValid || listDone || listErr) |-> $past(memReq, 2));

endmodule

bind dlist_walker dlist_walker_chk #(
  .MEM_WORDS (MEM_WORDS),
  .BOOT_WORDS(BOOT_WORDS)
) u_chk (
  .clk     (clk),
  .rstN    (rstN),
  .memReq  (memReq),
  .memAddr (memAddr),
  .entValid(entValid),
  .listDone(listDone),
  .listErr (listErr),
  .strobes (strobes)
);

// File: tb/sim_dlist_walker.sv
`timescale 1ns/1ps
module sim_dlist_walker;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        cfgWe = 1'b0;
  logic [1:0]  cfgChan = '0;
  logic [11:0] cfgAddr = '0;
  logic [5:0]  chanMode = 6'b010101;
  logic [2:0]  startPulse = '0;
  logic        memReq;
  logic [11:0] memAddr;
  logic [31:0] memRdata = '0;
  logic        entValid;
  logic [1:0]  outChan;
  logic [11:0] entAddr;
  logic [31:0] entCtrl;
  logic        listDone;
  logic        listErr;

  always #4 clk = ~clk;  // 125 MHz

  dlist_walker u0 (
    .clk(clk), .rstN(rstN), .cfgWe(cfgWe), .cfgChan(cfgChan), .cfgAddr(cfgAddr),
    .chanMode(chanMode), .startPulse(startPulse), .memReq(memReq), .memAddr(memAddr),
    .memRdata(memRdata), .entValid(entValid), .outChan(outChan), .entAddr(entAddr),
    .entCtrl(entCtrl), .listDone(listDone), .listErr(listErr)
  );

  // Sparse list memory with one-cycle read latency.
  logic [31:0] mem [int];
  function automatic logic [31:0] rd(input int a);
    return mem.exists(a) ? mem[a] : 32'h0;
  endfunction
  always @(posedge clk) if (memReq) memRdata <= rd(int'(memAddr));

  function automatic logic [31:0] hdr(input bit isEnd, input int size, input int tag);
    return {isEnd, 1'b0, 6'(size), 24'(tag)};
  endfunction

  int checks = 0;
  int errors = 0;
  int cyc = 0;
  bit finished = 0;

  int reqAddrQ[$], reqCycQ[$], entAddrQ[$], entChQ[$], entCycQ[$];
  int doneChQ[$], errChQ[$], errCycQ[$];
  logic [31:0] entCtrlQ[$];

  always @(posedge clk) cyc <= cyc + 1;

  always @(negedge clk) begin
    if (rstN) begin
      if (memReq) begin reqAddrQ.push_back(int'(memAddr)); reqCycQ.push_back(cyc); end
      if (entValid) begin
        entAddrQ.push_back(int'(entAddr)); entChQ.push_back(int'(outChan));
        entCycQ.push_back(cyc); entCtrlQ.push_back(entCtrl);
      end
      if (listDone) doneChQ.push_back(int'(outChan));
      if (listErr) begin errChQ.push_back(int'(outChan)); errCycQ.push_back(cyc); end
    end
  end

  task automatic chk(input bit ok, input string req, input string what,
                     input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic clearQ();
    reqAddrQ.delete(); reqCycQ.delete(); entAddrQ.delete(); entChQ.delete();
    entCycQ.delete(); entCtrlQ.delete(); doneChQ.delete(); errChQ.delete();
    errCycQ.delete();
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic setPtr(input int ch, input int addr);
    @(negedge clk); cfgWe = 1'b1; cfgChan = 2'(ch); cfgAddr = 12'(addr);
    @(negedge clk); cfgWe = 1'b0;
  endtask

  task automatic pulse(input logic [2:0] mask);
    @(negedge clk); startPulse = mask;
    @(negedge clk); startPulse = '0;
  endtask

  task automatic t_reset();
    chk(!memReq && !entValid && !listDone && !listErr, "R1", "outputs idle after reset",
        {memReq, entValid, listDone, listErr}, 0);
    mem[32] = hdr(0, 4, 'h11); mem[36] = hdr(1, 0, 0);
    clearQ(); pulse(3'b001); idle(8);
    chk(entAddrQ.size() == 1 && entAddrQ[0] == 32, "R1", "default pointer entry",
        entAddrQ.size() > 0 ? entAddrQ[0] : -1, 32);
    chk(entCtrlQ.size() == 1 && entCtrlQ[0] == hdr(0, 4, 'h11), "R3", "control word",
        entCtrlQ.size() > 0 ? entCtrlQ[0] : -1, hdr(0, 4, 'h11));
    chk(doneChQ.size() == 1 && doneChQ[0] == 0, "R4", "done on ch0", doneChQ.size(), 1);
  endtask

  task automatic t_ptrWrite();
    mem[500] = hdr(0, 3, 'h22); mem[503] = hdr(1, 0, 0);
    setPtr(1, 10); setPtr(1, 500); setPtr(1, 31);
    clearQ(); pulse(3'b010); idle(8);
    chk(reqAddrQ.size() > 0 && reqAddrQ[0] == 500, "R2", "boot-region write ignored",
        reqAddrQ.size() > 0 ? reqAddrQ[0] : -1, 500);
    chk(entChQ.size() == 1 && entChQ[0] == 1 && entAddrQ[0] == 500, "R2", "entry ch1",
        entAddrQ.size() > 0 ? entAddrQ[0] : -1, 500);
  endtask

  task automatic t_chain();
    mem[1000] = hdr(0, 5, 1); mem[1005] = hdr(0, 2, 2); mem[1007] = hdr(0, 7, 3);
    mem[1014] = hdr(1, 0, 0);
    setPtr(2, 1000); clearQ(); pulse(3'b100); idle(14);
    chk(entAddrQ.size() == 3, "R3", "entry count", entAddrQ.size(), 3);
    if (entAddrQ.size() == 3) begin
      chk(entAddrQ[0] == 1000, "R3", "entry 0", entAddrQ[0], 1000);
      chk(entAddrQ[1] == 1005, "R3", "entry 1", entAddrQ[1], 1005);
      chk(entAddrQ[2] == 1007, "R3", "entry 2", entAddrQ[2], 1007);
    end
    chk(doneChQ.size() == 1 && doneChQ[0] == 2, "R4", "done ch2", doneChQ.size(), 1);
    chk(reqAddrQ.size() == 4, "R4", "no read after terminator", reqAddrQ.size(), 4);
  endtask

  task automatic t_mode();
    mem[1200] = hdr(0, 1, 4); mem[1201] = hdr(1, 0, 0);
    setPtr(0, 1200);
    @(negedge clk); chanMode = 6'b010100;
    clearQ(); pulse(3'b001); idle(6);
    chk(reqAddrQ.size() == 0, "R5", "mode off ignores start", reqAddrQ.size(), 0);
    @(negedge clk); chanMode = 6'b010110;
    clearQ(); pulse(3'b001); idle(6);
    chk(reqAddrQ.size() == 0, "R5", "end-of-frame ignores start", reqAddrQ.size(), 0);
    @(negedge clk); chanMode = 6'b010111;
    clearQ(); pulse(3'b001); idle(8);
    chk(entAddrQ.size() == 1 && doneChQ.size() == 1, "R5", "mode 11 walks",
        entAddrQ.size(), 1);
    @(negedge clk); chanMode = 6'b010101;
  endtask

  task automatic t_zero();
    mem[2000] = hdr(0, 0, 5);
    setPtr(1, 2000); clearQ(); pulse(3'b010); idle(10);
    chk(errChQ.size() == 1 && errChQ[0] == 1, "R6", "zero size error", errChQ.size(), 1);
    chk(entAddrQ.size() == 0 && doneChQ.size() == 0 && reqAddrQ.size() == 1, "R6",
        "walk stops, no entry", reqAddrQ.size(), 1);
  endtask

  task automatic t_overrun();
    mem[4090] = hdr(0, 6, 6);
    setPtr(2, 4090); clearQ(); pulse(3'b100); idle(10);
    chk(entAddrQ.size() == 1 && entAddrQ[0] == 4090, "R7", "entry before overrun",
        entAddrQ.size(), 1);
    chk(errChQ.size() == 1 && entCycQ.size() == 1 && errCycQ[0] == entCycQ[0], "R7",
        "error with entry", errChQ.size(), 1);
    chk(reqAddrQ.size() == 1 && doneChQ.size() == 0, "R7", "overrun stops walk",
        reqAddrQ.size(), 1);
    mem[4090] = hdr(0, 5, 7); mem[4095] = hdr(1, 0, 0);
    clearQ(); pulse(3'b100); idle(10);
    chk(errChQ.size() == 0 && doneChQ.size() == 1 && entAddrQ.size() == 1, "R7",
        "last word reachable", errChQ.size(), 0);
  endtask

  task automatic t_rr();
    int expA[9] = '{100, 200, 300, 102, 202, 302, 105, 205, 305};
    for (int c = 0; c < 3; c++) begin
      mem[100*(c+1)]     = hdr(0, 2, c);
      mem[100*(c+1) + 2] = hdr(0, 3, c);
      mem[100*(c+1) + 5] = hdr(1, 0, 0);
      setPtr(c, 100*(c+1));
    end
    clearQ(); pulse(3'b111); idle(14);
    chk(reqAddrQ.size() == 9, "R8", "read count", reqAddrQ.size(), 9);
    if (reqAddrQ.size() == 9) begin
      for (int k = 0; k < 9; k++) begin
        chk(reqAddrQ[k] == expA[k], "R8", "rotating read order", reqAddrQ[k], expA[k]);
        chk(reqCycQ[k] == reqCycQ[0] + k, "R8", "back-to-back reads", reqCycQ[k],
            reqCycQ[0] + k);
      end
    end
    chk(doneChQ.size() == 3, "R8", "all lists done", doneChQ.size(), 3);
  endtask

  task automatic t_latency();
    mem[600] = hdr(0, 1, 8); mem[601] = hdr(1, 0, 0);
    setPtr(0, 600);
    @(negedge clk); startPulse = 3'b001;
    @(negedge clk); startPulse = '0;
    chk(memReq && memAddr == 600, "R9", "read one edge after start", memAddr, 600);
    @(negedge clk);
    chk(!entValid, "R9", "no entry two edges after start", entValid, 0);
    @(negedge clk);
    chk(entValid && entAddr == 600 && outChan == 0, "R9", "entry three edges after start",
        entAddr, 600);
    idle(6);
  endtask

  task automatic t_restart();
    for (int a = 3000; a < 3004; a++) mem[a] = hdr(0, 1, a);
    mem[3004] = hdr(1, 0, 0);
    setPtr(0, 3000); clearQ(); pulse(3'b001); idle(3); pulse(3'b001); idle(16);
    chk(entAddrQ.size() == 4, "R10", "no restart mid-walk", entAddrQ.size(), 4);
    if (entAddrQ.size() == 4)
      chk(entAddrQ[3] == 3003, "R10", "last entry", entAddrQ[3], 3003);
    chk(doneChQ.size() == 1, "R10", "single completion", doneChQ.size(), 1);
  endtask

  initial begin
    idle(3);
    rstN = 1'b1;
    idle(1);
    t_reset();
    t_ptrWrite();
    t_chain();
    t_mode();
    t_zero();
    t_overrun();
    t_rr();
    t_latency();
    t_restart();
    finished = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  always @(posedge clk) begin
    if (!finished && cyc > 20000) begin
      finished = 1;
      checks++;
      errors++;
      $display("FAIL R1 watchdog: actual %0d cycles expected below 20000", cyc);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

endmodule